// File: doc/BRIEF.md
# Pseudo-Static RAM Host Controller

This synchronous block sits between a clocked host and an asynchronous pseudo-static RAM of 128K bytes. The host presents single-byte reads and writes on a valid/ready handshake. The controller turns each request into a pin sequence. That sequence is one address setup cycle, a chip-enable low window of a fixed number of clocks, and a precharge window with chip enable high. Every timing value is a parameter counted in system clocks and rounded up from the nanosecond figure, so the same RTL serves any speed grade and any clock rate.

After reset the controller waits a power-up pause with all strobes inactive. It then runs a burst of dummy chip-enable cycles and only then opens the request port. From then on, a free-running timer marks a refresh as due at a fixed interval. The controller serves each due refresh as a chip-enable-only cycle that carries a 9-bit row counter on the low address bits. A refresh that falls due during an access waits until that access and its precharge end. A due refresh always wins over a waiting host request. The dedicated refresh pin is held inactive throughout.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_rfsh_n` and `mem_oe_n` are high and `req_ready` and `init_done` are low. Chip enable stays high for at least `INIT_CYC` cycles, then exactly `DUMMY_N` chip-enable-only cycles follow. Only then does `init_done` rise and requests become acceptable. `mem_rfsh_n` never goes low.
- R2: The address is on `mem_addr` for at least one cycle before chip enable falls, and it does not change while chip enable is low.
- R3: A read holds chip select high, output enable low and read/write high during the chip-enable low window. The byte on `mem_dq_in` in the last low cycle appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse in the cycle after chip enable rises.
- R4: A write holds read/write low for the whole chip-enable low window, and it rises together with chip enable. The write byte is driven (`mem_dq_oe` high) from the setup cycle until one cycle after chip enable rises, and is unchanged over that span.
- R5: Every chip-enable low window lasts exactly `CE_LOW` cycles, and chip enable stays high for at least `PRE` cycles between windows.
- R6: After initialisation, one refresh is issued per `REF_INT` cycles. It is a chip-enable cycle with output enable and read/write high, the row counter on `mem_addr[8:0]` and zeros above. The row advances by one per refresh, dummy cycles included, and wraps after 512.
- R7: A due refresh takes priority: `req_ready` stays low while a refresh is pending, so a waiting request is accepted only after the refresh and its precharge. Refresh keeps its rate under back-to-back host traffic.
- R8: `rsp_valid` pulses exactly once per accepted read and never for a write or a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DW | Read byte |
| init_done | output | 1 | Power-up sequence finished |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_cs | output | 1 | Memory chip select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_rw_n | output | 1 | Memory read (high) / write (low) |
| mem_rfsh_n | output | 1 | Memory refresh pin, held high |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the data pad driver |
| mem_dq_in | input | DW | Byte returned by the memory |

## Verification
A due refresh and a waiting host request can fall in the same idle cycle. This is the case that decides whether the ordering is right. The bench provokes it by streaming writes back to back with no gap, so that every refresh interval expires while a request is already waiting. It then reads all the streamed bytes back. A behavioural memory model checks address setup and hold, pulse widths, precharge and the sequence of refresh rows on every cycle. Correct ordering shows as a refresh count that keeps pace with the interval and as clean readback.

// File: rtl/psram_ctrl.sv
module psram_ctrl #(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int ROWW     = 9,
  parameter int INIT_CYC = 10000,
  parameter int DUMMY_N  = 8,
  parameter int CE_LOW   = 6,
  parameter int PRE      = 4,
  parameter int REF_INT  = 1560
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          init_done,
  output logic          mem_ce_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_rw_n,
  output logic          mem_rfsh_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int CW  = $clog2(INIT_CYC + CE_LOW + PRE + 2);
  localparam int TW  = $clog2(REF_INT + 1);
  localparam int DNW = $clog2(DUMMY_N + 1);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_SET, S_ACT, S_PRE} st_t;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_RF} op_t;

  st_t            st;
  op_t            op;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tmr;
  logic [DNW-1:0] dum;
  logic [ROWW-1:0] row;
  logic           ref_due;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;

  assign req_ready  = (st == S_IDLE) && !ref_due;
  assign mem_ce_n   = (st != S_ACT);
  assign mem_cs     = (st == S_SET) || (st == S_ACT) || (st == S_PRE);
  assign mem_oe_n   = !((st == S_ACT) && (op == OP_RD));
  assign mem_rw_n   = !((st == S_ACT) && (op == OP_WR));
  assign mem_rfsh_n = 1'b1;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (op == OP_WR) &&
                      ((st == S_SET) || (st == S_ACT) || ((st == S_PRE) && (cnt == '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_INIT; op <= OP_RF; cnt <= '0; tmr <= '0; dum <= '0; row <= '0;
      ref_due <= 1'b0; addr_q <= '0; wdata_q <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; init_done <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (init_done) begin
        if (tmr == TW'(REF_INT - 1)) begin
          tmr <= '0;
          ref_due <= 1'b1;
        end else tmr <= tmr + 1'b1;
      end
      case (st)
        S_INIT: begin
          if (cnt == CW'(INIT_CYC - 1)) begin
            cnt <= '0; st <= S_SET; op <= OP_RF; addr_q <= AW'(row);
          end else cnt <= cnt + 1'b1;
        end
        S_IDLE: begin
          if (ref_due) begin
            ref_due <= 1'b0; op <= OP_RF; addr_q <= AW'(row); st <= S_SET;
          end else if (req_valid) begin
            op <= req_we ? OP_WR : OP_RD;
            addr_q <= req_addr; wdata_q <= req_wdata; st <= S_SET;
          end
        end
        S_SET: begin
          st <= S_ACT; cnt <= '0;
        end
        S_ACT: begin
          if (cnt == CW'(CE_LOW - 1)) begin
            cnt <= '0; st <= S_PRE;
            if (op == OP_RD) begin
              rsp_rdata <= mem_dq_in; rsp_valid <= 1'b1;
            end
            if (op == OP_RF) begin
              row <= row + 1'b1;
              if (!init_done) dum <= dum + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_PRE: begin
          if (cnt == CW'(PRE - 1)) begin
            cnt <= '0;
            if (init_done) st <= S_IDLE;
            else if (dum == DNW'(DUMMY_N)) begin
              init_done <= 1'b1; st <= S_IDLE;
            end else begin
              st <= S_SET; addr_q <= AW'(row);
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_INIT;
      endcase
    end
  end

  logic [15:0] lo_cnt, hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0; hi_cnt <= '0;
    end else if (!mem_ce_n) begin
      lo_cnt <= lo_cnt + 1'b1; hi_cnt <= '0;
    end else begin
      lo_cnt <= '0;
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  a_r1_no_ready_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  a_r3_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_cs && mem_rw_n));
  a_r4_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rw_n |-> (mem_dq_oe && !mem_ce_n && mem_cs));
  a_r5_ce_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (lo_cnt == 16'(CE_LOW)));
  a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (hi_cnt >= 16'(PRE)));
  a_r8_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/psram_ctrl_tb_top.sv
module psram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17, DW = 8;
  localparam int INIT_CYC = 20, DUMMY_N = 8, CE_LOW = 3, PRE = 2, REF_INT = 60;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, init_done;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic mem_ce_n, mem_cs, mem_oe_n, mem_rw_n, mem_rfsh_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_ctrl #(.AW(AW), .DW(DW), .INIT_CYC(INIT_CYC), .DUMMY_N(DUMMY_N),
               .CE_LOW(CE_LOW), .PRE(PRE), .REF_INT(REF_INT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .init_done(init_done),
    .mem_ce_n(mem_ce_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_rw_n(mem_rw_n),
    .mem_rfsh_n(mem_rfsh_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] sb  [0:(1<<AW)-1];
  int checks = 0, errors = 0, cyc = 0;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_rw_n) ? mem[mem_addr] : 8'h00;

  int v_setup = 0, v_hold = 0, v_width = 0, v_pre = 0, v_wdata = 0, v_row = 0, v_cs = 0, v_rfsh = 0;
  int n_ref = 0, n_dummy = 0, n_rsp = 0, low_n = 0, high_n = 1000, first_fall = -1;
  bit prev_ce = 1, wr_seen = 0, rd_seen = 0, last_oe = 0;
  logic [AW-1:0] prev_addr = '0, lat_addr = '0;
  logic [DW-1:0] last_dq = '0;
  logic [8:0] exp_row = '0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_rfsh_n) v_rfsh++;
      if (rsp_valid) n_rsp++;
      if (prev_ce && !mem_ce_n) begin
        if (first_fall < 0) first_fall = cyc;
        if (high_n < PRE) v_pre++;
        if (mem_addr != prev_addr) v_setup++;
        if (!mem_cs) v_cs++;
        lat_addr = mem_addr; low_n = 1;
        wr_seen = !mem_rw_n; rd_seen = !mem_oe_n;
        last_dq = mem_dq_out; last_oe = mem_dq_oe;
      end else if (!mem_ce_n) begin
        low_n++;
        if (mem_addr != lat_addr) v_hold++;
        if (!mem_cs) v_cs++;
        if (!mem_rw_n) wr_seen = 1;
        if (!mem_oe_n) rd_seen = 1;
        last_dq = mem_dq_out; last_oe = mem_dq_oe;
      end else if (!prev_ce && mem_ce_n) begin
        if (low_n != CE_LOW) v_width++;
        if (wr_seen) begin
          if (!(last_oe && mem_dq_oe && mem_dq_out == last_dq)) v_wdata++;
          mem[lat_addr] = last_dq;
        end else if (!rd_seen) begin
          if (lat_addr != AW'(exp_row)) v_row++;
          exp_row++; n_ref++;
          if (!init_done) n_dummy++;
        end
        high_n = 1;
      end else if (high_n < 1000) high_n++;
      prev_ce = mem_ce_n; prev_addr = mem_addr;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 100000) begin
    errors++;
    $display("FAIL watchdog act=%0d exp=<100000", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    rd = '0;
    if (we) sb[a] = d;
    else begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end
  endtask

  typedef struct packed { logic we; logic [AW-1:0] addr; logic [DW-1:0] data; } vec_t;
  localparam vec_t VEC [12] = '{
    '{1'b1, 17'h00000, 8'hA5}, '{1'b1, 17'h1FFFF, 8'h3C}, '{1'b0, 17'h00000, 8'h00},
    '{1'b0, 17'h1FFFF, 8'h00}, '{1'b1, 17'h0ABCD, 8'hFF}, '{1'b1, 17'h10000, 8'h00},
    '{1'b0, 17'h0ABCD, 8'h00}, '{1'b0, 17'h10000, 8'h00}, '{1'b1, 17'h0ABCD, 8'h5A},
    '{1'b0, 17'h0ABCD, 8'h00}, '{1'b0, 17'h00200, 8'h00}, '{1'b1, 17'h001FF, 8'h81}};

  initial begin
    int reads = 0, r0;
    logic [DW-1:0] rd;
    for (int i = 0; i < (1<<AW); i++) begin mem[i] = '0; sb[i] = '0; end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_rfsh_n && mem_oe_n && !req_ready && !init_done, "R1 reset state",
        {mem_ce_n, mem_rfsh_n, mem_oe_n, req_ready, init_done}, 5'b11100);
    rst_n = 1;
    while (!init_done) @(negedge clk);
    chk(first_fall >= INIT_CYC, "R1 pause length", first_fall, INIT_CYC);
    chk(n_dummy == DUMMY_N, "R1 dummy count", n_dummy, DUMMY_N);
    chk(req_ready, "R1 ready after init", req_ready, 1);

    foreach (VEC[i]) begin
      xfer(VEC[i].we, VEC[i].addr, VEC[i].data, rd);
      if (!VEC[i].we) begin
        reads++;
        chk(rd == sb[VEC[i].addr], "R3 read data", rd, sb[VEC[i].addr]);
      end
    end

    r0 = n_rsp;
    xfer(1, 17'h00055, 8'h11, rd);
    repeat (8) @(negedge clk);
    chk(n_rsp == r0, "R8 no response to write", n_rsp, r0);
    xfer(0, 17'h00055, 8'h00, rd); reads++;
    chk(rd == 8'h11, "R4 written byte reads back", rd, 8'h11);

    r0 = n_ref;
    repeat (300) @(negedge clk);
    chk(n_ref - r0 >= 300 / REF_INT - 1, "R6 idle refresh rate", n_ref - r0, 300 / REF_INT - 1);

    r0 = n_ref;
    for (int i = 0; i < 30; i++) xfer(1, AW'(17'h00300 + i), DW'(i ^ 8'h5A), rd);
    chk(n_ref - r0 >= 2, "R7 refresh under streaming", n_ref - r0, 2);
    for (int i = 0; i < 30; i++) begin
      xfer(0, AW'(17'h00300 + i), 8'h00, rd); reads++;
      chk(rd == DW'(i ^ 8'h5A), "R7 streamed readback", rd, DW'(i ^ 8'h5A));
    end
    repeat (10) @(negedge clk);

    chk(n_rsp == reads, "R8 one response per read", n_rsp, reads);
    chk(v_setup == 0, "R2 address setup", v_setup, 0);
    chk(v_hold == 0, "R2 address hold", v_hold, 0);
    chk(v_cs == 0, "R3 chip select during access", v_cs, 0);
    chk(v_wdata == 0, "R4 write data hold", v_wdata, 0);
    chk(v_width == 0, "R5 chip-enable width", v_width, 0);
    chk(v_pre == 0, "R5 precharge", v_pre, 0);
    chk(v_row == 0, "R6 refresh row sequence", v_row, 0);
    chk(v_rfsh == 0, "R1 refresh pin idle", v_rfsh, 0);
    summary();
  end
endmodule